// File: doc/BRIEF.md
# Secured one-time-programmable window controller

This block sits next to the main array of a serial flash. It holds a small one-time-programmable (OTP) area and the security status that guards it. A command decoder in front of it passes each decoded opcode as a single-cycle strobe, together with the address captured for that command. Page data bytes and read-data requests follow as separate strobes, and the decoder also supplies the current write-enable latch.

Two opcodes open and close a window onto the OTP area. While the window is open, the ordinary read and page-program opcodes act on the 512-byte OTP store. The block then withholds the grant that would otherwise pass those commands, and every erase command, on to the main array. Programming can only clear bits. It is refused when the write-enable latch is low or when the area is locked. The area is locked either by a lock-down bit that software sets once, or by a factory-lock bit that is fixed by a parameter. Refused operations raise failure flags in the security register.

Top module: `otp_window`

## Requirements
- R1: After reset the window is closed, `main_grant` and `rd_valid` are 0, every OTP byte reads FFh, and `sec_reg` has only bit 0 set, and only when FACTORY_LOCK is 1.
- R2: Opcode B1h opens the window and opcode C1h closes it. `otp_mode` shows the new state one cycle after the strobe.
- R3: With the window open, read opcode 03h or 0Bh loads a byte pointer from address bits 8:0; higher bits are ignored. Each `rd_req` after that returns the byte under the pointer one cycle later with `rd_valid` high, then advances the pointer, and the pointer wraps from 511 to 0.
- R4: With the window open, opcode 02h with the write-enable latch high and the area unlocked loads the pointer the same way. Each `wr_valid` byte is then ANDed into the addressed byte and the pointer advances with wrap.
- R5: With the window closed, read (03h, 0Bh), program (02h) and erase (20h, 52h, D8h, 60h, C7h) opcodes raise `main_grant` for one cycle after the strobe. With the window open, no opcode raises it.
- R6: Opcode 2Fh with the write-enable latch high sets lock-down bit 1 of `sec_reg`. Only reset clears it. 2Fh with the latch low has no effect.
- R7: Opcode 02h with the window open, while bit 0 or bit 1 of `sec_reg` is set or while the write-enable latch is low, changes no byte, sets failure bit 5, and causes later `wr_valid` bytes to be dropped.
- R8: Any erase opcode with the window open sets failure bit 6 and leaves the OTP bytes unchanged.
- R9: Bit 5 is cleared by an accepted program: an OTP program, or a granted main-array program issued with the latch high. Bit 6 is cleared by a granted main-array erase issued with the latch high.
- R10: Opcode 2Bh returns `sec_reg` on `rd_data` with `rd_valid` high one cycle after the strobe.
- R11: A command strobe ends any read or program stream. A `wr_valid` or `rd_req` that arrives in the same cycle as a strobe is dropped. Bits 7, 4, 3 and 2 of `sec_reg` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_op | input | 8 | Opcode of the command |
| cmd_addr | input | ADDR_W | Address of the command |
| wel | input | 1 | Write-enable latch |
| wr_valid | input | 1 | Program data byte strobe |
| wr_data | input | 8 | Program data byte |
| rd_req | input | 1 | Request for the next read byte |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | OTP byte or security register value |
| otp_mode | output | 1 | Window open |
| main_grant | output | 1 | Command passed to the main array |
| sec_reg | output | 8 | Security register |

## Verification
A command strobe can coincide with a program data byte or with a read request. The bench provokes both cases: it raises `wr_valid` or `rd_req` in the same cycle as a new opcode, including an exit and a status read. It then judges the outcome by reading the affected bytes back afterwards and by checking that the only response is the one the opcode calls for. A behavioural reference model runs alongside the design and compares every output on every clock, both in directed sequences and in a long random mix of opcodes, latch values and strobes.

// File: rtl/otp_window.sv
module otp_window #(
  parameter int OTP_BYTES    = 512,
  parameter int ADDR_W       = 24,
  parameter bit FACTORY_LOCK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wel,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              otp_mode,
  output logic              main_grant,
  output logic [7:0]        sec_reg
);
  localparam int PW = $clog2(OTP_BYTES);
  localparam logic [7:0] OP_OPEN  = 8'hB1;
  localparam logic [7:0] OP_CLOSE = 8'hC1;
  localparam logic [7:0] OP_RSEC  = 8'h2B;
  localparam logic [7:0] OP_WSEC  = 8'h2F;

  logic [7:0]    mem [OTP_BYTES];
  logic [PW-1:0] ptr;
  logic          rd_act, pg_act, lockdown, pfail, efail;

  wire is_rd  = (cmd_op == 8'h03) || (cmd_op == 8'h0B);
  wire is_pp  = (cmd_op == 8'h02);
  wire is_er  = (cmd_op == 8'h20) || (cmd_op == 8'h52) || (cmd_op == 8'hD8) ||
                (cmd_op == 8'h60) || (cmd_op == 8'hC7);
  wire locked = FACTORY_LOCK | lockdown;
  wire rd_step = !cmd_valid && rd_req && rd_act;
  wire wr_step = !cmd_valid && wr_valid && pg_act;
  wire [PW-1:0] cmd_ptr = cmd_addr[PW-1:0];
  wire unused_addr_hi = ^cmd_addr[ADDR_W-1:PW];

  assign sec_reg = {1'b0, efail, pfail, 3'b000, lockdown, FACTORY_LOCK};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < OTP_BYTES; i++) mem[i] <= 8'hFF;
    end else if (wr_step) begin
      mem[ptr] <= mem[ptr] & wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      otp_mode   <= 1'b0;
      rd_act     <= 1'b0;
      pg_act     <= 1'b0;
      ptr        <= '0;
      lockdown   <= 1'b0;
      pfail      <= 1'b0;
      efail      <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= 8'h00;
      main_grant <= 1'b0;
    end else begin
      rd_valid   <= 1'b0;
      main_grant <= 1'b0;
      if (cmd_valid) begin
        rd_act <= 1'b0;
        pg_act <= 1'b0;
        if (cmd_op == OP_OPEN) otp_mode <= 1'b1;
        else if (cmd_op == OP_CLOSE) otp_mode <= 1'b0;
        else if (cmd_op == OP_RSEC) begin
          rd_valid <= 1'b1;
          rd_data  <= sec_reg;
        end else if (cmd_op == OP_WSEC) begin
          if (wel) lockdown <= 1'b1;
        end else if (!otp_mode) begin
          if (is_rd || is_pp || is_er) main_grant <= 1'b1;
          if (is_pp && wel) pfail <= 1'b0;
          if (is_er && wel) efail <= 1'b0;
        end else begin
          if (is_rd) begin
            rd_act <= 1'b1;
            ptr    <= cmd_ptr;
          end
          if (is_pp) begin
            if (locked || !wel) pfail <= 1'b1;
            else begin
              pfail  <= 1'b0;
              pg_act <= 1'b1;
              ptr    <= cmd_ptr;
            end
          end
          if (is_er) efail <= 1'b1;
        end
      end else if (rd_step) begin
        rd_valid <= 1'b1;
        rd_data  <= mem[ptr];
        ptr      <= ptr + 1'b1;
      end else if (wr_step) begin
        ptr <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/otp_window_chk.sv
module otp_window_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_op,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       otp_mode,
  input logic       main_grant,
  input logic [7:0] sec_reg
);
  a_r2_open: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 8'hB1 |=> otp_mode);
  a_r2_close: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 8'hC1 |=> !otp_mode);
  a_r5_no_grant_open: assert property (@(posedge clk) disable iff (!rst_n)
    otp_mode && cmd_valid |=> !main_grant);
  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sec_reg[1] |=> sec_reg[1]);
  a_r7_locked_fail: assert property (@(posedge clk) disable iff (!rst_n)
    otp_mode && cmd_valid && cmd_op == 8'h02 && (sec_reg[0] || sec_reg[1]) |=> sec_reg[5]);
  a_r8_erase_fail: assert property (@(posedge clk) disable iff (!rst_n)
    otp_mode && cmd_valid && cmd_op == 8'h20 |=> sec_reg[6]);
  a_r10_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 8'h2B |=> rd_valid && rd_data == $past(sec_reg));
  a_r11_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    sec_reg[7] == 1'b0 && sec_reg[4:2] == 3'b000);
endmodule

bind otp_window otp_window_chk u_chk (.*);

// File: tb/otp_window_tb.sv
module otp_window_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, wel = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] cmd_op = 8'h00, wr_data = 8'h00;
  logic [23:0] cmd_addr = 24'h0;
  logic rd_valid, otp_mode, main_grant;
  logic [7:0] rd_data, sec_reg;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  otp_window u_dut (.*);

  // reference model
  bit [7:0] m_mem [512];
  bit m_mode, m_rdact, m_pgact, m_lock, m_pf, m_ef, m_rv, m_mg;
  int m_ptr;
  bit [7:0] m_rd;

  function automatic bit [7:0] m_sec();
    return {1'b0, m_ef, m_pf, 3'b000, m_lock, 1'b0};
  endfunction

  function automatic bit op_er(bit [7:0] o);
    return o == 8'h20 || o == 8'h52 || o == 8'hD8 || o == 8'h60 || o == 8'hC7;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      {m_mode, m_rdact, m_pgact, m_lock, m_pf, m_ef, m_rv, m_mg} = '0;
      m_ptr = 0; m_rd = 0;
    end else begin
      bit [7:0] s;
      s = m_sec();
      m_rv = 0; m_mg = 0;
      if (cmd_valid) begin
        m_rdact = 0; m_pgact = 0;
        case (cmd_op)
          8'hB1: m_mode = 1;
          8'hC1: m_mode = 0;
          8'h2B: begin m_rv = 1; m_rd = s; end
          8'h2F: if (wel) m_lock = 1;
          default: begin
            bit rd, pp, er;
            rd = cmd_op == 8'h03 || cmd_op == 8'h0B;
            pp = cmd_op == 8'h02;
            er = op_er(cmd_op);
            if (!m_mode) begin
              m_mg = rd || pp || er;
              if (pp && wel) m_pf = 0;
              if (er && wel) m_ef = 0;
            end else begin
              if (rd) begin m_rdact = 1; m_ptr = cmd_addr % 512; end
              if (pp) begin
                if (m_lock || !wel) m_pf = 1;
                else begin m_pf = 0; m_pgact = 1; m_ptr = cmd_addr % 512; end
              end
              if (er) m_ef = 1;
            end
          end
        endcase
      end else if (rd_req && m_rdact) begin
        m_rv = 1; m_rd = m_mem[m_ptr]; m_ptr = (m_ptr + 1) % 512;
      end else if (wr_valid && m_pgact) begin
        m_mem[m_ptr] = m_mem[m_ptr] & wr_data; m_ptr = (m_ptr + 1) % 512;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(otp_mode == m_mode, "R2 otp_mode", otp_mode, m_mode);
    chk(main_grant == m_mg, "R5 main_grant", main_grant, m_mg);
    chk(sec_reg == m_sec(), "R6/R7/R8/R9 sec_reg", sec_reg, m_sec());
    chk(rd_valid == m_rv, "R3/R10 rd_valid", rd_valid, m_rv);
    if (m_rv) chk(rd_data == m_rd, "R3/R10 rd_data", rd_data, m_rd);
  end

  task automatic cmd(bit [7:0] op, bit [23:0] a = 0);
    cmd_valid = 1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wrb(bit [7:0] d);
    wr_valid = 1; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rdb(output bit [7:0] d);
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    d = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
  end

  initial begin
    bit [7:0] d;
    @(negedge clk);
    do_reset();
    chk(!otp_mode && !main_grant && !rd_valid && sec_reg == 8'h00, "R1 reset state", sec_reg, 0);

    // R5 grants with window closed; stray strobes ignored
    cmd(8'h03, 24'h10); cmd(8'h02, 24'h20); cmd(8'h20, 24'h0); cmd(8'h9F);
    rd_req = 1; wr_valid = 1; @(negedge clk); rd_req = 0; wr_valid = 0;

    // R2 open, R3 read with high bits ignored and wrap
    cmd(8'hB1);
    cmd(8'h03, 24'hABC1FE);
    rdb(d); chk(d == 8'hFF, "R1 erased byte", d, 8'hFF);
    rdb(d); rdb(d); rdb(d);

    // R7 program without latch
    cmd(8'h02, 24'h1FF); wrb(8'h00);
    cmd(8'h2B); chk(rd_data[5], "R7 pfail on no latch", rd_data, 8'h20);

    // R4 program with wrap, R9 pfail clears
    wel = 1;
    cmd(8'h02, 24'hFF01FF); wrb(8'hA5); wrb(8'h3C); wrb(8'h0F);
    chk(!sec_reg[5], "R9 pfail cleared", sec_reg, 0);
    cmd(8'h02, 24'h1FF); wrb(8'hF0);
    cmd(8'h0B, 24'h1FF);
    rdb(d); chk(d == 8'hA0, "R4 AND program", d, 8'hA0);
    rdb(d); chk(d == 8'h3C, "R4 wrap write", d, 8'h3C);
    rdb(d); chk(d == 8'h0F, "R4 third byte", d, 8'h0F);

    // R8 erase rejected in window
    cmd(8'h20, 24'h0); cmd(8'hC7);
    chk(sec_reg[6], "R8 efail", sec_reg, 8'h40);
    cmd(8'h03, 24'h0); rdb(d); chk(d == 8'h3C, "R8 contents kept", d, 8'h3C);

    // R11 collisions: data byte and read request with a command
    cmd(8'h02, 24'h40);
    cmd_valid = 1; cmd_op = 8'h02; cmd_addr = 24'h41; wr_valid = 1; wr_data = 8'h00;
    @(negedge clk); cmd_valid = 0; wr_valid = 0;
    wrb(8'h7E);
    cmd(8'h03, 24'h40);
    cmd_valid = 1; cmd_op = 8'h2B; rd_req = 1;
    @(negedge clk); cmd_valid = 0; rd_req = 0;
    chk(rd_valid && rd_data == sec_reg, "R11 status wins over read", rd_data, sec_reg);
    rdb(d); chk(!rd_valid, "R11 stream ended", rd_valid, 0);
    cmd(8'h03, 24'h40);
    rdb(d); chk(d == 8'hFF, "R11 dropped byte", d, 8'hFF);
    rdb(d); chk(d == 8'h7E, "R11 later byte", d, 8'h7E);
    cmd_valid = 1; cmd_op = 8'hC1; rd_req = 1;
    @(negedge clk); cmd_valid = 0; rd_req = 0;
    chk(!rd_valid && !otp_mode, "R11 exit with read", rd_valid, 0);

    // R9 main erase clears efail, R5 grant
    cmd(8'hD8, 24'h1000);
    chk(!sec_reg[6], "R9 efail cleared", sec_reg, 0);

    // R6 lock-down
    wel = 0; cmd(8'h2F);
    chk(!sec_reg[1], "R6 no latch no lock", sec_reg, 0);
    wel = 1; cmd(8'h2F);
    chk(sec_reg[1], "R6 lock set", sec_reg, 8'h02);
    cmd(8'hB1);
    cmd(8'h02, 24'h5); wrb(8'h00);
    chk(sec_reg[5], "R7 locked program", sec_reg, 8'h22);
    cmd(8'h03, 24'h5); rdb(d); chk(d == 8'hFF, "R7 byte untouched", d, 8'hFF);

    // R1 reset closes window and clears lock
    do_reset();
    chk(!otp_mode && sec_reg == 8'h00, "R1 reset after lock", sec_reg, 0);

    // random mix against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      wel = $urandom_range(0, 3) != 0;
      if (r < 25) begin
        bit [7:0] ops [13] = '{8'h03, 8'h0B, 8'h02, 8'h02, 8'h20, 8'h52, 8'hD8,
                               8'h60, 8'hC7, 8'hB1, 8'hC1, 8'h2B, 8'h9F};
        cmd_valid = 1;
        cmd_op = ($urandom_range(0, 199) == 0) ? 8'h2F : ops[$urandom_range(0, 12)];
        cmd_addr = 24'($urandom);
      end
      wr_valid = $urandom_range(0, 2) == 0;
      wr_data = 8'($urandom);
      rd_req = $urandom_range(0, 2) == 0;
      @(negedge clk);
      cmd_valid = 0; wr_valid = 0; rd_req = 0;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule